// File: doc/BRIEF.md
# Home-Node Presence-Vector Directory Controller

This block keeps coherence state for the memory lines owned by one home node in a system of a few caches. For every line it holds a word of `NCACHE+1` bits: bit 0 marks the line as dirty and bit `i+1` marks cache `i` as holding a copy. It also holds the line's memory word. Caches send it read misses, write misses, upgrades (a request to write a line they hold clean) and replacement notices. It answers with data replies, data-less grants and nacks. It sends targeted invalidations to the exact set of sharers, and it sends forward requests to the single owner of a dirty line. It tracks the acknowledgements that come back.

A line that waits for acknowledgements or for owner data is marked busy, and the block stores the id of the requester. Any request to a busy line gets a nack. Other lines are still served. The return channel (`ack_*`) carries both invalidation acknowledgements and owner data, and it always has priority over new requests.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every line is uncached and clean, the memory word of line L holds the value L, `req_ready` is 1 and no output message is valid.
- R2: A read (`req_kind`=0) of a line that is clean or uncached gets, in the cycle after acceptance, a reply with `rsp_kind`=0 (data) carrying the memory word. The requester is then recorded as a sharer.
- R3: A write (`req_kind`=1) of a clean line that other caches share sends one invalidation in the next cycle. Its `inv_mask` has bit i set for each other sharer i and excludes the requester. No reply is sent until the acknowledgement that brings the count to zero. The data reply comes in the cycle after that acknowledgement.
- R4: A write or upgrade of a clean line with no other sharer is answered in the cycle after acceptance, with no invalidation.
- R5: An upgrade (`req_kind`=2) from a cache recorded as a sharer ends in a grant (`rsp_kind`=1, data 0). An upgrade from a cache not recorded as a sharer is served as a write and ends in a data reply.
- R6: A read of a line dirty in cache k sends a forward to k and no reply. The next return on that line writes its data to memory, and the requester gets a data reply with that data. The line becomes clean, with k and the requester as sharers.
- R7: A write of a line dirty in cache k sends a forward to k. The returned data is written to memory and sent to the requester. The line becomes dirty with the requester as its only holder.
- R8: A clean replacement (`req_kind`=3) removes that cache from the sharers. A dirty replacement (`req_kind`=4) writes `req_data` to memory and leaves the line uncached. Neither produces an output message.
- R9: A request to a busy line gets a nack (`rsp_kind`=2) in the next cycle, and the line's state is left unchanged.
- R10: A return on a line that is not busy has no effect. A request to another line is served while a line is busy.
- R11: `req_ready` is 0 in every cycle in which `ack_valid` is 1, and a request offered in such a cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 3 | 0 read, 1 write, 2 upgrade, 3 clean replacement, 4 dirty replacement |
| req_src | input | IDW | Requesting cache |
| req_line | input | LW | Line index |
| req_data | input | DATA_W | Write-back data of a dirty replacement |
| ack_valid | input | 1 | Invalidation acknowledgement or owner data present |
| ack_line | input | LW | Line the return belongs to |
| ack_data | input | DATA_W | Owner data on a forward return |
| rsp_valid | output | 1 | Reply present |
| rsp_kind | output | 2 | 0 data, 1 grant, 2 nack |
| rsp_dst | output | IDW | Cache the reply goes to |
| rsp_line | output | LW | Line of the reply |
| rsp_data | output | DATA_W | Reply data |
| inv_valid | output | 1 | Invalidation present |
| inv_mask | output | NCACHE | Caches to invalidate, bit i for cache i |
| inv_line | output | LW | Line to invalidate |
| fwd_valid | output | 1 | Forward request present |
| fwd_dst | output | IDW | Owner asked to return the line |
| fwd_line | output | LW | Line requested from the owner |

## Verification
The bench builds the block with its defaults: four caches, sixteen lines and 32-bit data. Four caches are enough to have three sharers at once, so a single transaction must collect three acknowledgements. They also let a line pass from one owner to another through reads, writes, upgrades and both kinds of replacement, while a second line is served alongside. The bench infers the presence vector only from the invalidation masks and forward targets it later observes. With sixteen lines, an idle line can receive a stray return while another line is busy.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [2:0] {
        REQ_READ        = 3'd0,
        REQ_WRITE       = 3'd1,
        REQ_UPGRADE     = 3'd2,
        REQ_EVICT_CLEAN = 3'd3,
        REQ_EVICT_DIRTY = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_NACK  = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        PEND_INV_DATA  = 2'd0,
        PEND_INV_GRANT = 2'd1,
        PEND_FETCH_RD  = 2'd2,
        PEND_FETCH_WR  = 2'd3
    } pend_kind_e;

endpackage

// File: rtl/dir_popcount.sv
module dir_popcount #(
    parameter  int W  = 4,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/dir_owner_enc.sv
module dir_owner_enc #(
    parameter  int W  = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    // lowest set bit wins; a dirty line has exactly one bit set
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import dir_pkg::*;
#(
    parameter  int NCACHE = 4,
    parameter  int NLINES = 16,
    parameter  int DATA_W = 32,
    localparam int IDW    = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int LW     = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int CNTW   = $clog2(NCACHE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [IDW-1:0]    req_src,
    input  logic [LW-1:0]     req_line,
    input  logic [DATA_W-1:0] req_data,
    input  logic              ack_valid,
    input  logic [LW-1:0]     ack_line,
    input  logic [DATA_W-1:0] ack_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [IDW-1:0]    rsp_dst,
    output logic [LW-1:0]     rsp_line,
    output logic [DATA_W-1:0] rsp_data,
    output logic              inv_valid,
    output logic [NCACHE-1:0] inv_mask,
    output logic [LW-1:0]     inv_line,
    output logic              fwd_valid,
    output logic [IDW-1:0]    fwd_dst,
    output logic [LW-1:0]     fwd_line
);

    // entry layout: bit 0 dirty, bit i+1 set when cache i holds a copy
    typedef struct packed {
        logic       [NLINES-1:0][NCACHE:0]   entry;
        logic       [NLINES-1:0][DATA_W-1:0] mem;
        logic       [NLINES-1:0]             busy;
        pend_kind_e [NLINES-1:0]             pkind;
        logic       [NLINES-1:0][IDW-1:0]    preq;
        logic       [NLINES-1:0][CNTW-1:0]   pcnt;
        logic                                rsp_valid;
        rsp_kind_e                           rsp_kind;
        logic       [IDW-1:0]                rsp_dst;
        logic       [LW-1:0]                 rsp_line;
        logic       [DATA_W-1:0]             rsp_data;
        logic                                inv_valid;
        logic       [NCACHE-1:0]             inv_mask;
        logic       [LW-1:0]                 inv_line;
        logic                                fwd_valid;
        logic       [IDW-1:0]                fwd_dst;
        logic       [LW-1:0]                 fwd_line;
    } state_t;

    state_t s_d, s_q;

    // lookup of the requested line
    logic [NCACHE-1:0] src_bit;
    logic [NCACHE-1:0] cur_pres;
    logic              cur_dirty;
    logic [NCACHE-1:0] others;
    logic [IDW-1:0]    owner_idx;
    logic [CNTW-1:0]   others_cnt;
    logic [NCACHE-1:0] ack_req_bit;
    logic              ack_is_inv;
    logic              take_req;

    assign src_bit     = NCACHE'(1) << req_src;
    assign cur_pres    = s_q.entry[req_line][NCACHE:1];
    assign cur_dirty   = s_q.entry[req_line][0];
    assign others      = cur_pres & ~src_bit;
    assign ack_req_bit = NCACHE'(1) << s_q.preq[ack_line];
    assign ack_is_inv  = (s_q.pkind[ack_line] == PEND_INV_DATA) ||
                         (s_q.pkind[ack_line] == PEND_INV_GRANT);

    // returns always win over new requests
    assign req_ready = !ack_valid;
    assign take_req  = req_valid && req_ready;

    dir_owner_enc #(.W(NCACHE)) i_owner (
        .vec (cur_pres),
        .idx (owner_idx)
    );

    dir_popcount #(.W(NCACHE)) i_count (
        .vec (others),
        .cnt (others_cnt)
    );

    always_comb begin
        s_d = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.inv_valid = 1'b0;
        s_d.fwd_valid = 1'b0;

        // ---------------- return channel ----------------
        if (ack_valid && s_q.busy[ack_line]) begin
            if (ack_is_inv) begin
                if (s_q.pcnt[ack_line] == CNTW'(1)) begin
                    s_d.busy[ack_line] = 1'b0;
                    s_d.rsp_valid      = 1'b1;
                    s_d.rsp_dst        = s_q.preq[ack_line];
                    s_d.rsp_line       = ack_line;
                    if (s_q.pkind[ack_line] == PEND_INV_GRANT) begin
                        s_d.rsp_kind = RSP_GRANT;
                        s_d.rsp_data = '0;
                    end else begin
                        s_d.rsp_kind = RSP_DATA;
                        s_d.rsp_data = s_q.mem[ack_line];
                    end
                end else begin
                    s_d.pcnt[ack_line] = s_q.pcnt[ack_line] - CNTW'(1);
                end
            end else begin
                s_d.mem[ack_line]  = ack_data;
                s_d.busy[ack_line] = 1'b0;
                if (s_q.pkind[ack_line] == PEND_FETCH_RD) begin
                    s_d.entry[ack_line] = {s_q.entry[ack_line][NCACHE:1] | ack_req_bit, 1'b0};
                end else begin
                    s_d.entry[ack_line] = {ack_req_bit, 1'b1};
                end
                s_d.rsp_valid = 1'b1;
                s_d.rsp_kind  = RSP_DATA;
                s_d.rsp_dst   = s_q.preq[ack_line];
                s_d.rsp_line  = ack_line;
                s_d.rsp_data  = ack_data;
            end
        end

        // ---------------- request channel ----------------
        if (take_req) begin
            if (s_q.busy[req_line]) begin
                s_d.rsp_valid = 1'b1;
                s_d.rsp_kind  = RSP_NACK;
                s_d.rsp_dst   = req_src;
                s_d.rsp_line  = req_line;
                s_d.rsp_data  = '0;
            end else begin
                unique case (req_kind_e'(req_kind))
                    REQ_READ: begin
                        if (cur_dirty) begin
                            s_d.busy[req_line]  = 1'b1;
                            s_d.pkind[req_line] = PEND_FETCH_RD;
                            s_d.preq[req_line]  = req_src;
                            s_d.fwd_valid       = 1'b1;
                            s_d.fwd_dst         = owner_idx;
                            s_d.fwd_line        = req_line;
                        end else begin
                            s_d.entry[req_line] = {cur_pres | src_bit, 1'b0};
                            s_d.rsp_valid       = 1'b1;
                            s_d.rsp_kind        = RSP_DATA;
                            s_d.rsp_dst         = req_src;
                            s_d.rsp_line        = req_line;
                            s_d.rsp_data        = s_q.mem[req_line];
                        end
                    end
                    REQ_WRITE, REQ_UPGRADE: begin
                        if (cur_dirty) begin
                            s_d.busy[req_line]  = 1'b1;
                            s_d.pkind[req_line] = PEND_FETCH_WR;
                            s_d.preq[req_line]  = req_src;
                            s_d.fwd_valid       = 1'b1;
                            s_d.fwd_dst         = owner_idx;
                            s_d.fwd_line        = req_line;
                        end else begin
                            s_d.entry[req_line] = {src_bit, 1'b1};
                            if (others == '0) begin
                                s_d.rsp_valid = 1'b1;
                                s_d.rsp_dst   = req_src;
                                s_d.rsp_line  = req_line;
                                if (req_kind_e'(req_kind) == REQ_UPGRADE && (cur_pres & src_bit) != '0) begin
                                    s_d.rsp_kind = RSP_GRANT;
                                    s_d.rsp_data = '0;
                                end else begin
                                    s_d.rsp_kind = RSP_DATA;
                                    s_d.rsp_data = s_q.mem[req_line];
                                end
                            end else begin
                                s_d.busy[req_line] = 1'b1;
                                s_d.preq[req_line] = req_src;
                                s_d.pcnt[req_line] = others_cnt;
                                if (req_kind_e'(req_kind) == REQ_UPGRADE && (cur_pres & src_bit) != '0) begin
                                    s_d.pkind[req_line] = PEND_INV_GRANT;
                                end else begin
                                    s_d.pkind[req_line] = PEND_INV_DATA;
                                end
                                s_d.inv_valid = 1'b1;
                                s_d.inv_mask  = others;
                                s_d.inv_line  = req_line;
                            end
                        end
                    end
                    REQ_EVICT_CLEAN: begin
                        s_d.entry[req_line][NCACHE:1] = others;
                        if (others == '0) s_d.entry[req_line][0] = 1'b0;
                    end
                    REQ_EVICT_DIRTY: begin
                        s_d.mem[req_line]   = req_data;
                        s_d.entry[req_line] = '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int l = 0; l < NLINES; l++) begin
                s_q.mem[l] <= DATA_W'(l);
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_kind  = s_q.rsp_kind;
    assign rsp_dst   = s_q.rsp_dst;
    assign rsp_line  = s_q.rsp_line;
    assign rsp_data  = s_q.rsp_data;
    assign inv_valid = s_q.inv_valid;
    assign inv_mask  = s_q.inv_mask;
    assign inv_line  = s_q.inv_line;
    assign fwd_valid = s_q.fwd_valid;
    assign fwd_dst   = s_q.fwd_dst;
    assign fwd_line  = s_q.fwd_line;

    // ---------------- assertions ----------------
    for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
        assert_dirty_one_holder_R7: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.entry[g][0] |-> ($countones(s_q.entry[g][NCACHE:1]) == 1));
        assert_pending_acks_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.busy[g] && (s_q.pkind[g] == PEND_INV_DATA || s_q.pkind[g] == PEND_INV_GRANT))
            |-> (s_q.pcnt[g] != '0));
    end

    assert_nack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && s_q.busy[req_line]) |=> (rsp_valid && rsp_kind == RSP_NACK));

    assert_inv_has_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_mask != '0));

    assert_fwd_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (!inv_valid && !rsp_valid));

endmodule

// File: tb/test_dir_ctrl.sv
module test_dir_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [3:0]  req_line = '0;
    logic [31:0] req_data = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_line = '0;
    logic [31:0] ack_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [1:0]  rsp_dst;
    logic [3:0]  rsp_line;
    logic [31:0] rsp_data;
    logic        inv_valid;
    logic [3:0]  inv_mask;
    logic [3:0]  inv_line;
    logic        fwd_valid;
    logic [1:0]  fwd_dst;
    logic [3:0]  fwd_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_ctrl i_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line), .req_data(req_data),
        .ack_valid(ack_valid), .ack_line(ack_line), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
        .rsp_line(rsp_line), .rsp_data(rsp_data),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_line(inv_line),
        .fwd_valid(fwd_valid), .fwd_dst(fwd_dst), .fwd_line(fwd_line)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input int k, input int src, input int line, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(k); req_src = 2'(src);
        req_line = 4'(line); req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_ack(input int line, input logic [31:0] d);
        @(negedge clk);
        ack_valid = 1'b1; ack_line = 4'(line); ack_data = d;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    // expect a reply (and no invalidation/forward) after the last step
    task automatic exp_rsp(input string tag, input int kind, input int dst, input int line, input logic [31:0] d);
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " rsp_kind"},  64'(rsp_kind), 64'(kind));
        chk({tag, " rsp_dst"},   64'(rsp_dst), 64'(dst));
        chk({tag, " rsp_line"},  64'(rsp_line), 64'(line));
        chk({tag, " rsp_data"},  64'(rsp_data), 64'(d));
        chk({tag, " no inv/fwd"}, 64'({inv_valid, fwd_valid}), 64'd0);
    endtask

    task automatic exp_inv(input string tag, input int mask, input int line);
        chk({tag, " inv_valid"}, 64'(inv_valid), 64'd1);
        chk({tag, " inv_mask"},  64'(inv_mask), 64'(mask));
        chk({tag, " inv_line"},  64'(inv_line), 64'(line));
        chk({tag, " no rsp"},    64'(rsp_valid), 64'd0);
    endtask

    task automatic exp_fwd(input string tag, input int dst, input int line);
        chk({tag, " fwd_valid"}, 64'(fwd_valid), 64'd1);
        chk({tag, " fwd_dst"},   64'(fwd_dst), 64'(dst));
        chk({tag, " fwd_line"},  64'(fwd_line), 64'(line));
        chk({tag, " no rsp"},    64'(rsp_valid), 64'd0);
    endtask

    task automatic exp_quiet(input string tag);
        chk({tag, " quiet"}, 64'({rsp_valid, inv_valid, fwd_valid}), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        exp_quiet("R1 outputs after reset");
        do_req(1, 1, 5, 0);
        exp_rsp("R1/R4 write uncached line 5", 0, 1, 5, 32'd5);
    endtask

    task automatic t_share_and_write;
        do_req(0, 1, 3, 0); exp_rsp("R2 read c1 line 3", 0, 1, 3, 32'd3);
        do_req(0, 2, 3, 0); exp_rsp("R2 read c2 line 3", 0, 2, 3, 32'd3);
        do_req(1, 1, 3, 0); exp_inv("R3 write c1 line 3", 4'b0100, 3);
        do_ack(3, 0);       exp_rsp("R3 reply after ack line 3", 0, 1, 3, 32'd3);
    endtask

    task automatic t_busy_line;
        do_req(0, 0, 7, 0); exp_rsp("R2 read c0 line 7", 0, 0, 7, 32'd7);
        do_req(0, 1, 7, 0); exp_rsp("R2 read c1 line 7", 0, 1, 7, 32'd7);
        do_req(0, 2, 7, 0); exp_rsp("R2 read c2 line 7", 0, 2, 7, 32'd7);
        do_req(2, 3, 7, 0); exp_inv("R5 upgrade non-sharer c3", 4'b0111, 7);
        do_req(0, 0, 7, 0); exp_rsp("R9 nack on busy line 7", 2, 0, 7, 32'd0);
        do_req(0, 0, 8, 0); exp_rsp("R10 other line served", 0, 0, 8, 32'd8);
        do_ack(9, 32'hFFFF); exp_quiet("R10 stray ack line 9");
        do_ack(7, 0); exp_quiet("R3 first of three acks");
        do_ack(7, 0); exp_quiet("R3 second of three acks");
        do_ack(7, 0); exp_rsp("R5 data after last ack", 0, 3, 7, 32'd7);
    endtask

    task automatic t_upgrade_grant;
        do_req(0, 0, 2, 0); exp_rsp("R2 read c0 line 2", 0, 0, 2, 32'd2);
        do_req(0, 1, 2, 0); exp_rsp("R2 read c1 line 2", 0, 1, 2, 32'd2);
        do_req(2, 0, 2, 0); exp_inv("R5 upgrade sharer c0", 4'b0010, 2);
        do_ack(2, 0);       exp_rsp("R5 grant after ack", 1, 0, 2, 32'd0);
        do_req(0, 2, 4, 0); exp_rsp("R2 read c2 line 4", 0, 2, 4, 32'd4);
        do_req(2, 2, 4, 0); exp_rsp("R4 sole-sharer upgrade grant", 1, 2, 4, 32'd0);
    endtask

    task automatic t_read_dirty;
        // line 7 is dirty in c3
        do_req(0, 1, 7, 0);          exp_fwd("R6 read dirty fwd to c3", 3, 7);
        do_ack(7, 32'h0000_AAAA);    exp_rsp("R6 owner data to c1", 0, 1, 7, 32'h0000_AAAA);
        do_req(1, 0, 7, 0);          exp_inv("R6 sharers c3 and c1", 4'b1010, 7);
        do_ack(7, 0);                exp_quiet("R6 first ack");
        do_ack(7, 0);                exp_rsp("R6 memory updated", 0, 0, 7, 32'h0000_AAAA);
    endtask

    task automatic t_write_dirty;
        // line 7 is dirty in c0
        do_req(1, 2, 7, 0);          exp_fwd("R7 write dirty fwd to c0", 0, 7);
        do_ack(7, 32'h0000_BBBB);    exp_rsp("R7 owner data to c2", 0, 2, 7, 32'h0000_BBBB);
        do_req(0, 1, 7, 0);          exp_fwd("R7 new owner is c2", 2, 7);
        do_ack(7, 32'h0000_CCCC);    exp_rsp("R6 data to c1", 0, 1, 7, 32'h0000_CCCC);
    endtask

    task automatic t_replace;
        // line 7 clean, sharers c2 and c1
        do_req(3, 1, 7, 0);          exp_quiet("R8 clean replacement c1");
        do_req(1, 3, 7, 0);          exp_inv("R8 c1 no longer sharer", 4'b0100, 7);
        do_ack(7, 0);                exp_rsp("R8 data to c3", 0, 3, 7, 32'h0000_CCCC);
        do_req(4, 3, 7, 32'h0000_DDDD); exp_quiet("R8 dirty replacement c3");
        do_req(0, 0, 7, 0);          exp_rsp("R8 written-back data from memory", 0, 0, 7, 32'h0000_DDDD);
        do_req(1, 2, 7, 0);          exp_inv("R8 only c0 shares after write-back", 4'b0001, 7);
        do_ack(7, 0);                exp_rsp("R8 data to c2", 0, 2, 7, 32'h0000_DDDD);
    endtask

    task automatic t_priority;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd0; req_src = 2'd0; req_line = 4'd10;
        ack_valid = 1'b1; ack_line = 4'd11; ack_data = '0;
        #1;
        chk("R11 ready low with ack", 64'(req_ready), 64'd0);
        @(negedge clk);
        req_valid = 1'b0; ack_valid = 1'b0;
        exp_quiet("R11 request not taken");
        do_req(0, 0, 10, 0); exp_rsp("R11 request taken later", 0, 0, 10, 32'd10);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_share_and_write();
        t_busy_line();
        t_upgrade_grant();
        t_read_dirty();
        t_write_dirty();
        t_replace();
        t_priority();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule